// File: doc/BRIEF.md
# Two-Input Join Node with Input Hold

This block is a computation node that joins two token flows, left and right, into one output flow. Each input carries a valid bit and a data word. The node fires in a cycle only when a token is available from both sides. Firing emits one output token whose data is the sum of the two operands. Which cycle a token arrives in has no effect on the result; only the presence of tokens decides when the node fires.

A single one-slot holding stage sits in front of each input. When a token arrives on one side and the other side has nothing to offer, the hold for that side is raised. The hold is a combinational function of the other side's presence. The token is captured and kept for as many cycles as needed, then presented together with its partner. The block reports every idle cycle that has a token waiting, and it tells which side is missing. There is no back-pressure to upstream. A token that arrives on a side whose slot is already occupied, while the partner is still absent, is dropped and flagged.

Top module: `join2_hold`

## Requirements
- R1: After reset both slots are empty. With no input valid, out_vld, stall and ovf are all 0.
- R2: With both slots empty and both inputs valid in the same cycle, out_vld is 1 in that cycle. out_data equals l_data + r_data, computed at width DW+1 so that the carry is kept.
- R3: A left token that arrives while the right side has no token is captured. In that cycle stall is 2'b01 (waiting on the right). In the first later cycle with r_vld, the node fires with the captured left data and the new right data.
- R4: A right token that arrives while the left side has no token is captured. In that cycle stall is 2'b10 (waiting on the left). In the first later cycle with l_vld, the node fires with the captured right data and the new left data.
- R5: Suppose a side's slot is full, a new token arrives on that side, and the partner is available. The node fires with the held token, not the new one, and the new token takes the slot.
- R6: Suppose a side's slot is full, a new token arrives on that side, and the partner is absent. ovf is 1 in that cycle, the new token is dropped, and the held token is kept for the next firing.
- R7: In a cycle where the node does not fire and no token is held or arriving, stall is 2'b00. stall is also 2'b00 in every firing cycle.
- R8: At most one token per side reaches the node in a cycle, and the two slots are never both full. Each firing consumes exactly one token from each side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_vld | input | 1 | Left token present |
| l_data | input | DW | Left token payload |
| r_vld | input | 1 | Right token present |
| r_data | input | DW | Right token payload |
| out_vld | output | 1 | Node fires, output token present |
| out_data | output | DW+1 | Sum of the two operands |
| stall | output | 2 | 00 fire or nothing pending, 01 waiting on right, 10 waiting on left |
| ovf | output | 1 | Token dropped: it arrived on a full slot while the partner was absent |

## Verification
The bench builds the block with DW=4. At that width the sum carry bit is set often, and repeated operand values make it clear whether a held token or a newly arrived one was used. Random valid patterns on the two sides, each side valid about half the time, produce long one-sided runs. These runs reach capture, burst replacement and overflow many times. A short directed sequence first visits each of these cases on its own.

// File: rtl/join2_hold.sv
module join2_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_vld,
  input  logic [DW-1:0] l_data,
  input  logic          r_vld,
  input  logic [DW-1:0] r_data,
  output logic          out_vld,
  output logic [DW:0]   out_data,
  output logic [1:0]    stall,
  output logic          ovf
);
  localparam int OW = DW + 1;
  localparam logic [1:0] ST_NONE   = 2'b00;
  localparam logic [1:0] ST_WAIT_R = 2'b01;
  localparam logic [1:0] ST_WAIT_L = 2'b10;

  logic          l_full, r_full;
  logic [DW-1:0] l_q, r_q;
  logic          l_av, r_av, fire;
  logic          l_hold, r_hold;
  logic [DW-1:0] l_op, r_op;

  assign l_av = l_vld | l_full;
  assign r_av = r_vld | r_full;
  assign fire = l_av & r_av;

  assign l_hold = l_vld & ~r_av;
  assign r_hold = r_vld & ~l_av;

  assign l_op = l_full ? l_q : l_data;
  assign r_op = r_full ? r_q : r_data;

  assign out_vld  = fire;
  assign out_data = OW'(l_op) + OW'(r_op);
  assign ovf      = (l_hold & l_full) | (r_hold & r_full);

  always_comb begin
    if (fire)      stall = ST_NONE;
    else if (l_av) stall = ST_WAIT_R;
    else if (r_av) stall = ST_WAIT_L;
    else           stall = ST_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_full <= 1'b0;
      r_full <= 1'b0;
      l_q    <= '0;
      r_q    <= '0;
    end else begin
      if (fire)                 l_full <= l_full & l_vld;
      else if (l_hold)          l_full <= 1'b1;
      if (fire)                 r_full <= r_full & r_vld;
      else if (r_hold)          r_full <= 1'b1;
      if (l_vld && (l_full ? fire : l_hold)) l_q <= l_data;
      if (r_vld && (r_full ? fire : r_hold)) r_q <= r_data;
    end
  end
endmodule

module join2_hold_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_vld,
  input logic [DW-1:0] l_data,
  input logic          r_vld,
  input logic [DW-1:0] r_data,
  input logic          out_vld,
  input logic [DW:0]   out_data,
  input logic [1:0]    stall,
  input logic          ovf,
  input logic          l_full,
  input logic          r_full,
  input logic [DW-1:0] l_q,
  input logic [DW-1:0] r_q
);
  AST_HOLD_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (l_vld && !r_vld && !l_full && !r_full) |=> (l_full && l_q == $past(l_data))); // R3
  AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (r_vld && !l_vld && !r_full && !l_full) |=> (r_full && r_q == $past(r_data))); // R4
  AST_HELD_LEFT_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (l_full && r_vld) |-> (out_vld && out_data == (DW+1)'(l_q) + (DW+1)'(r_data))); // R3
  AST_BURST_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (l_full && l_vld && r_vld) |=> (l_full && l_q == $past(l_data))); // R5
  AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && l_full) |=> (l_full && l_q == $past(l_q))); // R6
  AST_STALL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stall) && !(out_vld && stall != 2'b00)); // R7
  AST_ONE_SIDE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_full && r_full)); // R8
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    (!rst_n) |=> (!l_full && !r_full)); // R1
endmodule

bind join2_hold join2_hold_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .l_vld(l_vld), .l_data(l_data),
  .r_vld(r_vld), .r_data(r_data), .out_vld(out_vld), .out_data(out_data),
  .stall(stall), .ovf(ovf), .l_full(l_full), .r_full(r_full),
  .l_q(l_q), .r_q(r_q)
);

// File: tb/tb_join2_hold.sv
`timescale 1ns/100ps
module tb_join2_hold;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          l_vld = 1'b0, r_vld = 1'b0;
  logic [DW-1:0] l_data = '0, r_data = '0;
  logic          out_vld;
  logic [DW:0]   out_data;
  logic [1:0]    stall;
  logic          ovf;

  int n_chk = 0, n_bad = 0;
  int exp_fires = 0, obs_fires = 0;
  bit m_lf = 0, m_rf = 0;
  int m_lq = 0, m_rq = 0;

  always #2.5 clk = ~clk;

  join2_hold #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .l_vld(l_vld), .l_data(l_data),
    .r_vld(r_vld), .r_data(r_data), .out_vld(out_vld), .out_data(out_data),
    .stall(stall), .ovf(ovf)
  );

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int exp_stall(bit lav, bit rav);
    if (lav && rav) return 0;
    if (lav) return 1;
    if (rav) return 2;
    return 0;
  endfunction

  function automatic string fire_req(bit lv, bit rv);
    if ((m_lf && lv) || (m_rf && rv)) return "R5";
    if (m_lf) return "R3";
    if (m_rf) return "R4";
    return "R2";
  endfunction

  task automatic step(bit lv, int ld, bit rv, int rd);
    bit lav, rav, efire, eovf;
    int lop, rop, est;
    string rq;
    @(negedge clk);
    l_vld = lv; l_data = DW'(ld); r_vld = rv; r_data = DW'(rd);
    #1;
    lav = lv | m_lf; rav = rv | m_rf; efire = lav & rav;
    lop = m_lf ? m_lq : ld % (1 << DW);
    rop = m_rf ? m_rq : rd % (1 << DW);
    est = exp_stall(lav, rav);
    eovf = (m_lf && lv && !rav) || (m_rf && rv && !lav);
    rq = efire ? fire_req(lv, rv) : "R7";
    chk(rq, "out_vld", int'(out_vld), int'(efire));
    if (efire) chk(rq, "out_data", int'(out_data), lop + rop);
    chk(est == 1 ? "R3" : est == 2 ? "R4" : "R7", "stall", int'(stall), est);
    chk("R6", "ovf", int'(ovf), int'(eovf));
    if (out_vld) obs_fires++;
    if (efire) begin
      exp_fires++;
      if (m_lf) begin m_lf = lv; if (lv) m_lq = ld % (1 << DW); end
      if (m_rf) begin m_rf = rv; if (rv) m_rq = rd % (1 << DW); end
    end else begin
      if (lv && !m_lf) begin m_lf = 1; m_lq = ld % (1 << DW); end
      if (rv && !m_rf) begin m_rf = 1; m_rq = rd % (1 << DW); end
    end
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1d2c;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "out_vld after reset", int'(out_vld), 0);
    chk("R1", "stall after reset", int'(stall), 0);
    chk("R1", "ovf after reset", int'(ovf), 0);
    step(0, 0, 0, 0);
    step(1, 3, 1, 5);
    step(1, 9, 0, 0);
    step(0, 0, 1, 12);
    step(0, 0, 1, 7);
    step(1, 15, 1, 15);
    step(1, 2, 0, 0);
    step(1, 4, 0, 0);
    step(1, 6, 0, 0);
    step(0, 0, 0, 0);
    step(0, 0, 1, 1);
    step(0, 0, 1, 8);
    step(0, 0, 1, 9);
    step(1, 10, 0, 0);
    for (int i = 0; i < 4000; i++)
      step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
           bit'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
    chk("R8", "firing count", obs_fires, exp_fires);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule